// File: doc/BRIEF.md
# One-Time-Programmable Fuse Array Controller

This block holds a small one-time-programmable fuse store of 32 bytes, kept in flip-flops that clear only on a power-on reset. Software reaches it through a simple word-wide register port. Reads return a 4-byte little-endian word at a word-aligned offset. A write burns the non-zero bytes of a word into the cells, one byte at a time, each byte taking a programmable number of clocks.

A fuse byte takes exactly one program operation. After that the byte is locked, and the lock bit sits in the fuse bank itself, so a soft reset of the controller does not free the byte again. Programming is refused unless an active-low enable control has been driven to 0. Three control words sit just above the array. The pulse-width register sets the clocks spent on each byte. The enable register holds the active-low program enable. The status register shows the done, busy and error flags.

Read data is decoded combinationally from the address alone. The access strobe only updates the error flag and starts programming.

Top module: `otp_fuse_ctrl`

## Requirements
- R1: After power-on reset every array word reads 0. Status (offset 0x28: bit0 done, bit1 busy, bit2 error) reads 0. The enable register (offset 0x24, bit0) reads 1. The pulse-width register (offset 0x20) reads its reset value of 4.
- R2: An array word at offset o is made of bytes o..o+3, and byte o sits in data bits 7:0 (little-endian). The array spans offsets 0x00 to 0x1C.
- R3: Programming only ORs bits into a cell, so no write ever clears a bit that is already set.
- R4: A byte is programmed only if its write data is non-zero, and it is then locked. A non-zero write to a locked byte leaves that byte unchanged and sets the error flag, while the unlocked bytes of the same word are still programmed.
- R5: An array write while the enable bit is 1 changes nothing and sets the error flag.
- R6: An array-window access to a misaligned offset, to an offset above 0x1C, or to an address that is not a control word sets the error flag, leaves the array unchanged and reads 0. A valid array access clears the flag.
- R7: With pulse width T, byte k of an accepted write (k = 0..3) appears in the array exactly (k+1)*T clocks after the accepting edge. Busy reads 1 from the accepting edge until done sets, at 4*T clocks.
- R8: The done flag clears on the edge that accepts a write and stays clear while busy.
- R9: A soft reset (rst_n) restores the control registers but keeps the fuse contents and locks. Only the power-on reset (por_n) clears them.
- R10: While busy, an array write is rejected with the error flag set, and writes to the pulse-width and enable registers are ignored.
- R11: A pulse width of 0 is treated as 1 clock per byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Active-low power-on reset; clears the fuse cells, the locks and the control logic |
| rst_n | input | 1 | Active-low soft reset of the control logic only |
| bus_req | input | 1 | Access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |

## Verification
The bench builds the block with its defaults: 32 bytes, 4-byte words, an 8-bit pulse register with reset value 4. At run time it sets pulse widths of 3 and 0. A width of 3 spreads the four byte commits of a word over separate edges, so each commit edge and the done edge can be sampled on its own. A width of 0 checks the clamp to one clock. Because the locks are stored in the cell bank, a soft reset in the middle of the run shows that the locks survive. A later power-on reset shows that the bank can be fresh again.

// File: rtl/otp_fuse_pkg.sv
`timescale 1ns/1ps
package otp_fuse_pkg;
   typedef enum logic {SEQ_IDLE, SEQ_PULSE} seq_state_e;

   // control word index above the array
   localparam int unsigned REG_PULSE = 0;
   localparam int unsigned REG_PGMN  = 1;
   localparam int unsigned REG_STAT  = 2;
   localparam int unsigned NUM_CTL   = 3;

   // status bit positions
   localparam int unsigned ST_DONE = 0;
   localparam int unsigned ST_BUSY = 1;
   localparam int unsigned ST_ERR  = 2;
endpackage

// File: rtl/otp_fuse_cells.sv
`timescale 1ns/1ps
module otp_fuse_cells #(
   parameter int unsigned NBYTES = 32,
   localparam int unsigned IDX_W = $clog2(NBYTES)
) (
   input  logic                  clk,
   input  logic                  por_n,
   input  logic                  fire_i,
   input  logic [IDX_W-1:0]      fire_idx_i,
   input  logic [7:0]            fire_data_i,
   output logic [NBYTES*8-1:0]   cells_o,
   output logic [NBYTES-1:0]     locks_o
);
   for (genvar g = 0; g < NBYTES; g++) begin : g_byte
      logic [7:0] cell_q;
      logic       lock_q;
      always_ff @(posedge clk or negedge por_n) begin
         if (!por_n) begin
            cell_q <= '0;
            lock_q <= 1'b0;
         end else if (fire_i && (fire_idx_i == IDX_W'(g)) && !lock_q) begin
            cell_q <= cell_q | fire_data_i;
            lock_q <= 1'b1;
         end
      end
      assign cells_o[g*8 +: 8] = cell_q;
      assign locks_o[g]        = lock_q;
   end
endmodule

// File: rtl/otp_fuse_seq.sv
`timescale 1ns/1ps
module otp_fuse_seq
   import otp_fuse_pkg::*;
#(
   parameter int unsigned WORD_BYTES = 4,
   parameter int unsigned PW_W       = 8,
   parameter int unsigned IDX_W      = 5,
   localparam int unsigned SUB_W     = $clog2(WORD_BYTES),
   localparam int unsigned DATA_W    = 8*WORD_BYTES
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start_i,
   input  logic [IDX_W-1:0]      base_i,
   input  logic [DATA_W-1:0]     word_i,
   input  logic [WORD_BYTES-1:0] mask_i,
   input  logic [PW_W-1:0]       pw_i,
   output logic                  busy_o,
   output logic                  done_o,
   output logic                  fire_o,
   output logic [IDX_W-1:0]      fire_idx_o,
   output logic [7:0]            fire_data_o
);
   seq_state_e            state_q;
   logic [PW_W-1:0]       cnt_q, pw_q;
   logic [SUB_W-1:0]      sub_q;
   logic [DATA_W-1:0]     word_q;
   logic [WORD_BYTES-1:0] mask_q;
   logic [IDX_W-1:0]      base_q;
   logic                  done_q;
   logic                  step, last;

   assign step        = (state_q == SEQ_PULSE) && (cnt_q == pw_q);
   assign last        = (sub_q == SUB_W'(WORD_BYTES-1));
   assign fire_o      = step && mask_q[sub_q];
   assign fire_idx_o  = base_q + IDX_W'(sub_q);
   assign fire_data_o = word_q[{sub_q, 3'b000} +: 8];
   assign busy_o      = (state_q == SEQ_PULSE);
   assign done_o      = done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SEQ_IDLE;
         cnt_q   <= '0;
         pw_q    <= '0;
         sub_q   <= '0;
         word_q  <= '0;
         mask_q  <= '0;
         base_q  <= '0;
         done_q  <= 1'b0;
      end else if (start_i) begin
         state_q <= SEQ_PULSE;
         cnt_q   <= PW_W'(1);
         pw_q    <= (pw_i == '0) ? PW_W'(1) : pw_i;
         sub_q   <= '0;
         word_q  <= word_i;
         mask_q  <= mask_i;
         base_q  <= base_i;
         done_q  <= 1'b0;
      end else if (state_q == SEQ_PULSE) begin
         if (step) begin
            cnt_q <= PW_W'(1);
            if (last) begin
               state_q <= SEQ_IDLE;
               done_q  <= 1'b1;
            end else begin
               sub_q <= sub_q + SUB_W'(1);
            end
         end else begin
            cnt_q <= cnt_q + PW_W'(1);
         end
      end
   end
endmodule

// File: rtl/otp_fuse_ctrl.sv
`timescale 1ns/1ps
module otp_fuse_ctrl
   import otp_fuse_pkg::*;
#(
   parameter int unsigned NBYTES     = 32,
   parameter int unsigned WORD_BYTES = 4,
   parameter int unsigned ADDR_W     = 8,
   parameter int unsigned PW_W       = 8,
   parameter int unsigned PW_RESET   = 4,
   localparam int unsigned DATA_W    = 8*WORD_BYTES
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              rst_n,
   input  logic              bus_req,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata
);
   localparam int unsigned IDX_W  = $clog2(NBYTES);
   localparam int unsigned AL_W   = $clog2(WORD_BYTES);
   localparam int unsigned WIDX_W = IDX_W - AL_W;
   localparam int unsigned CS_W   = ADDR_W - AL_W;

   // elaboration-time parameter checks
   if ((WORD_BYTES < 2) || ((1 << AL_W) != WORD_BYTES)) begin : g_bad_word
      $error("WORD_BYTES must be a power of two, at least 2");
   end
   if (((1 << IDX_W) != NBYTES) || (NBYTES <= WORD_BYTES)) begin : g_bad_depth
      $error("NBYTES must be a power of two above WORD_BYTES");
   end
   if ((NBYTES + NUM_CTL*WORD_BYTES) > (1 << ADDR_W)) begin : g_bad_addr
      $error("ADDR_W too narrow for array plus control words");
   end
   if ((PW_W > DATA_W) || (PW_RESET >= (1 << PW_W))) begin : g_bad_pw
      $error("pulse register width or reset value out of range");
   end

   logic [NBYTES*8-1:0]   cell_bits;
   logic [NBYTES-1:0]     lock_bits;
   logic                  seq_busy, seq_done, seq_fire;
   logic [IDX_W-1:0]      fire_idx;
   logic [7:0]            fire_data;

   logic [PW_W-1:0]       pw_q;
   logic                  pgm_n_q, err_q;

   // address decode
   logic                  aligned, in_arr, arr_ok, ctl_hit;
   logic [CS_W-1:0]       ctl_sel;
   logic [WIDX_W-1:0]     widx;
   logic [IDX_W-1:0]      base;
   logic [DATA_W-1:0]     arr_word;

   assign aligned  = (bus_addr[AL_W-1:0] == '0);
   assign in_arr   = (bus_addr < ADDR_W'(NBYTES));
   assign arr_ok   = in_arr && aligned;
   assign ctl_sel  = bus_addr[ADDR_W-1:AL_W] - CS_W'(NBYTES >> AL_W);
   assign ctl_hit  = !in_arr && aligned && (ctl_sel < CS_W'(NUM_CTL));
   assign widx     = bus_addr[IDX_W-1:AL_W];
   assign base     = {widx, {AL_W{1'b0}}};
   assign arr_word = cell_bits[{base, 3'b000} +: DATA_W];

   // per-byte program / clash masks
   logic [WORD_BYTES-1:0] prog_mask, lock_clash;
   for (genvar b = 0; b < WORD_BYTES; b++) begin : g_lane
      logic lane_lock, lane_nz;
      assign lane_lock     = lock_bits[base + IDX_W'(b)];
      assign lane_nz       = |bus_wdata[b*8 +: 8];
      assign prog_mask[b]  = lane_nz && !lane_lock;
      assign lock_clash[b] = lane_nz && lane_lock;
   end

   // read mux
   always_comb begin
      bus_rdata = '0;
      if (arr_ok) begin
         bus_rdata = arr_word;
      end else if (ctl_hit) begin
         if (ctl_sel == CS_W'(REG_PULSE)) begin
            bus_rdata[PW_W-1:0] = pw_q;
         end else if (ctl_sel == CS_W'(REG_PGMN)) begin
            bus_rdata[0] = pgm_n_q;
         end else begin
            bus_rdata[ST_DONE] = seq_done;
            bus_rdata[ST_BUSY] = seq_busy;
            bus_rdata[ST_ERR]  = err_q;
         end
      end
   end

   // access strobes
   logic wr_arr, rd_arr, wr_ctl, start, wr_err;
   assign wr_arr = bus_req && bus_we && !ctl_hit;
   assign rd_arr = bus_req && !bus_we && !ctl_hit;
   assign wr_ctl = bus_req && bus_we && ctl_hit && !seq_busy;
   assign start  = wr_arr && arr_ok && !pgm_n_q && !seq_busy;
   assign wr_err = !arr_ok || pgm_n_q || seq_busy || (|lock_clash);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pw_q    <= PW_W'(PW_RESET);
         pgm_n_q <= 1'b1;
         err_q   <= 1'b0;
      end else begin
         if (wr_arr) begin
            err_q <= wr_err;
         end else if (rd_arr) begin
            err_q <= !arr_ok;
         end
         if (wr_ctl && (ctl_sel == CS_W'(REG_PULSE))) begin
            pw_q <= bus_wdata[PW_W-1:0];
         end
         if (wr_ctl && (ctl_sel == CS_W'(REG_PGMN))) begin
            pgm_n_q <= bus_wdata[0];
         end
      end
   end

   otp_fuse_seq #(
      .WORD_BYTES (WORD_BYTES),
      .PW_W       (PW_W),
      .IDX_W      (IDX_W)
   ) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start),
      .base_i      (base),
      .word_i      (bus_wdata),
      .mask_i      (prog_mask),
      .pw_i        (pw_q),
      .busy_o      (seq_busy),
      .done_o      (seq_done),
      .fire_o      (seq_fire),
      .fire_idx_o  (fire_idx),
      .fire_data_o (fire_data)
   );

   otp_fuse_cells #(
      .NBYTES (NBYTES)
   ) u_cells (
      .clk         (clk),
      .por_n       (por_n),
      .fire_i      (seq_fire),
      .fire_idx_i  (fire_idx),
      .fire_data_i (fire_data),
      .cells_o     (cell_bits),
      .locks_o     (lock_bits)
   );
endmodule

// File: rtl/otp_fuse_ctrl_chk.sv
`timescale 1ns/1ps
module otp_fuse_ctrl_chk #(
   parameter int unsigned NBYTES = 32
) (
   input logic                clk,
   input logic                por_n,
   input logic                rst_n,
   input logic [NBYTES*8-1:0] cells,
   input logic [NBYTES-1:0]   locks,
   input logic                busy,
   input logic                done
);
   logic [NBYTES*8-1:0] lock_mask;
   for (genvar g = 0; g < NBYTES; g++) begin : g_mask
      assign lock_mask[g*8 +: 8] = {8{locks[g]}};
      p_lock_nonzero_r4 : assert property (@(posedge clk) disable iff (!por_n)
         locks[g] |-> (cells[g*8 +: 8] != 8'h00));
   end

   p_bits_only_rise_r3 : assert property (@(posedge clk) disable iff (!por_n)
      $past(por_n) |-> ((cells & $past(cells)) == $past(cells)));

   p_locked_frozen_r4 : assert property (@(posedge clk) disable iff (!por_n)
      $past(por_n) |-> ((cells & $past(lock_mask)) == ($past(cells) & $past(lock_mask))));

   p_lock_sticky_r9 : assert property (@(posedge clk) disable iff (!por_n)
      $past(por_n) |-> ((locks & $past(locks)) == $past(locks)));

   p_change_needs_busy_r7 : assert property (@(posedge clk) disable iff (!por_n)
      ($past(por_n) && (cells != $past(cells))) |-> $past(busy));

   p_busy_not_done_r8 : assert property (@(posedge clk) disable iff (!rst_n || !por_n)
      busy |-> !done);
endmodule

bind otp_fuse_ctrl otp_fuse_ctrl_chk #(.NBYTES(NBYTES)) u_chk (
   .clk   (clk),
   .por_n (por_n),
   .rst_n (rst_n),
   .cells (cell_bits),
   .locks (lock_bits),
   .busy  (seq_busy),
   .done  (seq_done)
);

// File: tb/otp_fuse_ctrl_tb.sv
`timescale 1ns/1ps
module otp_fuse_ctrl_tb;
   localparam logic [7:0] A_PULSE = 8'h20;
   localparam logic [7:0] A_PGMN  = 8'h24;
   localparam logic [7:0] A_STAT  = 8'h28;

   logic        clk = 1'b0;
   logic        por_n = 1'b0;
   logic        rst_n = 1'b0;
   logic        req = 1'b0;
   logic        we = 1'b0;
   logic [7:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;

   int checks = 0;
   int fails  = 0;

   always #4 clk = ~clk;

   otp_fuse_ctrl u_dut (
      .clk       (clk),
      .por_n     (por_n),
      .rst_n     (rst_n),
      .bus_req   (req),
      .bus_we    (we),
      .bus_addr  (addr),
      .bus_wdata (wdata),
      .bus_rdata (rdata)
   );

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", tag, got, exp);
      end
   endtask

   task automatic peek(input logic [7:0] a, output logic [31:0] d);
      addr = a;
      #1;
      d = rdata;
   endtask

   task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      req = 1'b1; we = 1'b1; addr = a; wdata = d;
      @(posedge clk);
      @(negedge clk);
      req = 1'b0; we = 1'b0;
   endtask

   task automatic bus_read_strobe(input logic [7:0] a);
      @(negedge clk);
      req = 1'b1; we = 1'b0; addr = a;
      @(posedge clk);
      @(negedge clk);
      req = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wait_done();
      logic [31:0] s;
      for (int i = 0; i < 200; i++) begin
         peek(A_STAT, s);
         if (s[1] == 1'b0) break;
         @(negedge clk);
      end
   endtask

   task automatic t_reset();
      logic [31:0] d;
      logic [31:0] acc;
      acc = '0;
      for (int o = 0; o < 32; o += 4) begin
         peek(8'(o), d);
         acc = acc | d;
      end
      check("R1 array zero", acc, 32'h0);
      peek(A_STAT, d);  check("R1 status", d, 32'h0);
      peek(A_PGMN, d);  check("R1 enable", d, 32'h1);
      peek(A_PULSE, d); check("R1 pulse", d, 32'h4);
   endtask

   task automatic t_no_enable();
      logic [31:0] d;
      bus_write(8'h00, 32'hDEADBEEF);
      peek(A_STAT, d); check("R5 error set", d, 32'h4);
      idle(20);
      peek(8'h00, d);  check("R5 array untouched", d, 32'h0);
   endtask

   task automatic t_timing();
      logic [31:0] d, s;
      bus_write(A_PGMN, 32'h0);
      bus_write(A_PULSE, 32'h3);
      bus_write(8'h08, 32'h44332211);
      peek(A_STAT, s); check("R8 done clear, busy", s, 32'h2);
      for (int n = 1; n <= 12; n++) begin
         @(posedge clk);
         @(negedge clk);
         peek(8'h08, d);
         peek(A_STAT, s);
         if (n == 2)  check("R7 nothing at 2", d, 32'h0);
         if (n == 3)  check("R7 R2 byte0 at 3", d, 32'h00000011);
         if (n == 5)  check("R7 byte1 not yet", d, 32'h00000011);
         if (n == 6)  check("R7 R2 byte1 at 6", d, 32'h00002211);
         if (n == 11) begin
            check("R7 three bytes at 11", d, 32'h00332211);
            check("R8 still busy at 11", s, 32'h2);
         end
         if (n == 12) begin
            check("R2 full word", d, 32'h44332211);
            check("R7 done at 12", s, 32'h1);
         end
      end
   endtask

   task automatic t_lock();
      logic [31:0] d;
      bus_write(8'h0C, 32'h00AA0000);
      wait_done();
      peek(8'h0C, d); check("R4 single byte", d, 32'h00AA0000);
      bus_write(8'h0C, 32'h77665544);
      peek(A_STAT, d); check("R4 clash error while busy", d, 32'h6);
      wait_done();
      peek(A_STAT, d); check("R4 error kept after done", d, 32'h5);
      peek(8'h0C, d);  check("R4 others programmed", d, 32'h77AA5544);
      bus_write(8'h0C, 32'h0);
      wait_done();
      peek(8'h0C, d);  check("R3 no bit cleared", d, 32'h77AA5544);
      peek(A_STAT, d); check("R3 zero write no error", d, 32'h1);
   endtask

   task automatic t_align();
      logic [31:0] d;
      bus_write(8'h09, 32'hFFFFFFFF);
      peek(A_STAT, d); check("R6 misaligned write error", d, 32'h5);
      idle(20);
      peek(8'h08, d);  check("R6 array unchanged", d, 32'h44332211);
      peek(8'h09, d);  check("R6 misaligned reads 0", d, 32'h0);
      bus_read_strobe(8'h00);
      peek(A_STAT, d); check("R6 valid read clears error", d, 32'h1);
      bus_write(8'h2C, 32'h1);
      peek(A_STAT, d); check("R6 beyond control error", d, 32'h5);
      peek(8'h2C, d);  check("R6 beyond reads 0", d, 32'h0);
      bus_read_strobe(8'h05);
      peek(A_STAT, d); check("R6 misaligned read error", d, 32'h5);
   endtask

   task automatic t_busy();
      logic [31:0] d;
      bus_write(8'h10, 32'h000000C3);
      bus_write(8'h14, 32'h12345678);
      peek(A_STAT, d);  check("R10 busy write error", d, 32'h6);
      bus_write(A_PULSE, 32'h9);
      peek(A_PULSE, d); check("R10 pulse write ignored", d, 32'h3);
      bus_write(A_PGMN, 32'h1);
      peek(A_PGMN, d);  check("R10 enable write ignored", d, 32'h0);
      wait_done();
      peek(8'h14, d);   check("R10 rejected word empty", d, 32'h0);
      peek(8'h10, d);   check("R10 first word done", d, 32'h000000C3);
   endtask

   task automatic t_zero_pulse();
      logic [31:0] s;
      bus_write(A_PULSE, 32'h0);
      bus_write(8'h18, 32'h01010101);
      for (int n = 1; n <= 4; n++) begin
         @(posedge clk);
         @(negedge clk);
         peek(A_STAT, s);
         if (n == 3) check("R11 busy at 3", s, 32'h2);
         if (n == 4) check("R11 done at 4", s, 32'h1);
      end
   endtask

   task automatic t_soft_reset();
      logic [31:0] d;
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      peek(A_PGMN, d);  check("R9 enable restored", d, 32'h1);
      peek(A_PULSE, d); check("R9 pulse restored", d, 32'h4);
      peek(8'h18, d);   check("R9 contents kept", d, 32'h01010101);
      bus_write(A_PGMN, 32'h0);
      bus_write(8'h18, 32'h02020202);
      peek(A_STAT, d);  check("R9 lock survives", d, 32'h6);
      wait_done();
      peek(8'h18, d);   check("R9 locked word unchanged", d, 32'h01010101);
      @(negedge clk); por_n = 1'b0; rst_n = 1'b0;
      @(negedge clk); por_n = 1'b1; rst_n = 1'b1;
      peek(8'h18, d);   check("R9 power-on clears", d, 32'h0);
      bus_write(A_PGMN, 32'h0);
      bus_write(8'h18, 32'h0000F000);
      wait_done();
      peek(8'h18, d);   check("R9 reprogram after power-on", d, 32'h0000F000);
      peek(A_STAT, d);  check("R9 clean status", d, 32'h1);
   endtask

   initial begin : watchdog
      #(8*200000);
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin : main
      idle(3);
      por_n = 1'b1;
      rst_n = 1'b1;
      idle(1);
      t_reset();
      t_no_enable();
      t_timing();
      t_lock();
      t_align();
      t_busy();
      t_zero_pulse();
      t_soft_reset();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule